// File: doc/BRIEF.md
# Priority Arbiter for Multi-Channel DMA Single Transfers

This block chooses which of `NCH` DMA channels owns the bus for the next single data transfer. Each channel drives three inputs: an active request, a two-bit priority level and a flag. The flag is set when the channel is moving a block from memory to memory. The arbiter issues a one-hot grant with a valid strobe. It holds that grant until the transfer engine pulses `xfer_done` at the end of the single transfer. It then returns to idle and arbitrates again on the next cycle.

Priority is resolved in two stages. The highest level among the active requests wins. Among requesters on that level, the lowest channel index wins. A memory-to-memory channel must step aside after each of its single transfers. If any other channel is requesting in the following arbitration cycle, that channel takes the bus, even when its level is lower. The memory-to-memory channel gets the bus back directly only when it is the sole requester.

Top module: `dma_prio_arbiter`

## Requirements
- R1: Channel `i` uses priority field `ch_prio[2*i+1:2*i]`, coded as 2'b11 very high, 2'b10 high, 2'b01 medium and 2'b00 low. The grant goes to a requester on the highest coded level present among the active requests.
- R2: When several requesters share the winning level, the grant goes to the one with the lowest index. Grant bit `i` stands for channel `i`.
- R3: The channel just served may have had its memory-to-memory flag set when it was granted. In that case, if any other channel requests in the next arbitration cycle, the grant goes to the best of those other requesters under R1 and R2, even when its level is lower.
- R4: If the just-served memory-to-memory channel is the only requester in the next arbitration cycle, it is granted again.
- R5: If a request is present while the arbiter is idle, `gnt`/`gnt_vld` show the grant after the next clock edge. The grant stays unchanged until the edge that samples `xfer_done` high. After that edge `gnt_vld` is low and `gnt` is zero for at least one idle cycle.
- R6: While no request is active in an idle cycle, `gnt_vld` stays low and `gnt` stays all zeros.
- R7: Request changes while a grant is outstanding do not alter the grant. A request that is withdrawn before an idle cycle samples it is never granted.
- R8: An `xfer_done` pulse while the arbiter is idle has no effect.
- R9: Driving `rst_n` low clears `gnt` and `gnt_vld` at once. It also clears the memory-to-memory yield history.
- R10: A channel whose flag was clear when it was served receives no yield treatment, so it can win the very next arbitration again under R1 and R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the chip |
| ch_req | input | NCH | Active request per channel |
| ch_prio | input | 2*NCH | Two-bit priority level per channel, channel `i` in bits `2i+1:2i` |
| ch_m2m | input | NCH | Channel is running a memory-to-memory block |
| xfer_done | input | 1 | Pulse marking the end of the granted single transfer |
| gnt | output | NCH | One-hot grant, zero when no grant is held |
| gnt_vld | output | 1 | A grant is outstanding |

## Verification
The bench pits a very-high memory-to-memory channel against a low-level requester to confirm that the bus changes hands. A design that ignored the yield rule would keep granting the memory-to-memory channel. The bench also checks the opposite cases. A lone memory-to-memory requester must be granted again, where an over-eager yield would stall it. A normal channel must be able to win twice in a row, where a yield applied to every channel would wrongly rotate the bus. Ties on one level separate a lowest-index pick from a highest-index pick. A request raised and dropped during a busy period must not be granted later, which exposes a design that latches requests. A spurious `xfer_done` while idle must leave the arbiter idle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    PRIO_LOW   = 2'b00,
    PRIO_MED   = 2'b01,
    PRIO_HIGH  = 2'b10,
    PRIO_VHIGH = 2'b11
  } prio_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } arb_state_e;

  localparam int PRIO_W = 2;

endpackage

// File: rtl/dma_arb_mask.sv
// Removes the just-served memory-to-memory channel from the candidate set
// whenever some other channel is also requesting.
module dma_arb_mask #(
  parameter int NCH = 7
) (
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] yield_mask,
  output logic [NCH-1:0] elig
);

  logic [NCH-1:0] others;

  always_comb begin
    others = req & ~yield_mask;
    if (|others) elig = others;
    else         elig = req;
  end

endmodule

// File: rtl/dma_arb_pick.sv
// Level-then-index resolution: highest coded level wins, lowest index breaks ties.
module dma_arb_pick
  import dma_arb_pkg::*;
#(
  parameter int NCH = 7,
  parameter int PW  = PRIO_W
) (
  input  logic [NCH-1:0]    elig,
  input  logic [PW*NCH-1:0] prio,
  output logic [NCH-1:0]    win,
  output logic              any
);

  localparam int LEVELS = 1 << PW;

  logic [LEVELS-1:0][NCH-1:0] lvl_hit;
  logic [NCH-1:0]             top_set;

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      assign lvl_hit[lv][ch] = elig[ch] && (prio[ch*PW +: PW] == PW'(lv));
    end
  end

  // Later (higher) levels overwrite earlier ones, leaving the top populated level.
  always_comb begin
    top_set = '0;
    for (int lv = 0; lv < LEVELS; lv++) begin
      if (|lvl_hit[lv]) top_set = lvl_hit[lv];
    end
  end

  // Isolate lowest set bit for index tie-break.
  assign win = top_set & (~top_set + NCH'(1));
  assign any = |elig;

endmodule

// File: rtl/dma_arb_ctrl.sv
// Grant holding state machine plus yield history.
module dma_arb_ctrl
  import dma_arb_pkg::*;
#(
  parameter int NCH = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] win,
  input  logic           any,
  input  logic [NCH-1:0] m2m,
  input  logic           xfer_done,
  output logic [NCH-1:0] gnt,
  output logic           gnt_vld,
  output logic [NCH-1:0] yield_mask
);

  arb_state_e     state_q, state_d;
  logic [NCH-1:0] gnt_q, gnt_d;
  logic           gm2m_q, gm2m_d;
  logic [NCH-1:0] yld_q, yld_d;
  logic           issue, release_bus, upd_en;

  assign issue       = (state_q == ST_IDLE) && any;
  assign release_bus = (state_q == ST_BUSY) && xfer_done;
  assign upd_en      = issue || release_bus;

  always_comb begin
    state_d = state_q;
    gnt_d   = gnt_q;
    gm2m_d  = gm2m_q;
    yld_d   = yld_q;
    if (issue) begin
      state_d = ST_BUSY;
      gnt_d   = win;
      gm2m_d  = |(win & m2m);
      yld_d   = '0;
    end else if (release_bus) begin
      state_d = ST_IDLE;
      gnt_d   = '0;
      gm2m_d  = 1'b0;
      yld_d   = gm2m_q ? gnt_q : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gnt_q   <= '0;
      gm2m_q  <= 1'b0;
      yld_q   <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      gnt_q   <= gnt_d;
      gm2m_q  <= gm2m_d;
      yld_q   <= yld_d;
    end
  end

  assign gnt        = gnt_q;
  assign gnt_vld    = (state_q == ST_BUSY);
  assign yield_mask = yld_q;

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     ch_req,
  input  logic [2*NCH-1:0]   ch_prio,
  input  logic [NCH-1:0]     ch_m2m,
  input  logic               xfer_done,
  output logic [NCH-1:0]     gnt,
  output logic               gnt_vld
);

  logic [NCH-1:0] yield_mask;
  logic [NCH-1:0] elig;
  logic [NCH-1:0] win;
  logic           any;

  dma_arb_mask #(.NCH(NCH)) u_mask (
    .req        (ch_req),
    .yield_mask (yield_mask),
    .elig       (elig)
  );

  dma_arb_pick #(.NCH(NCH), .PW(PRIO_W)) u_pick (
    .elig (elig),
    .prio (ch_prio),
    .win  (win),
    .any  (any)
  );

  dma_arb_ctrl #(.NCH(NCH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .win        (win),
    .any        (any),
    .m2m        (ch_m2m),
    .xfer_done  (xfer_done),
    .gnt        (gnt),
    .gnt_vld    (gnt_vld),
    .yield_mask (yield_mask)
  );

endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int NCH = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] ch_req,
  input logic           xfer_done,
  input logic [NCH-1:0] gnt,
  input logic           gnt_vld
);

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> $onehot0(gnt) && (gnt != '0));                       // R2

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_vld |-> (gnt == '0));                                       // R6

  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && !xfer_done) |=> (gnt_vld && $stable(gnt)));          // R5

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && xfer_done) |=> !gnt_vld);                            // R5

  AST_GNT_WAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_vld) |-> ((gnt & $past(ch_req)) != '0));               // R7

  AST_IDLE_DONE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_vld && (ch_req == '0)) |=> !gnt_vld);                      // R8

endmodule

bind dma_prio_arbiter dma_arb_checker #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ch_req    (ch_req),
  .xfer_done (xfer_done),
  .gnt       (gnt),
  .gnt_vld   (gnt_vld)
);

// File: tb/tb_dma_prio_arbiter.sv
module tb_dma_prio_arbiter;

  localparam int NCH = 7;

  logic                  clk;
  logic                  rst_n;
  logic [NCH-1:0]        req;
  logic [NCH-1:0][1:0]   pr;
  logic [NCH-1:0]        m2m;
  logic                  done;
  logic [NCH-1:0]        gnt;
  logic                  gnt_vld;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  string tag_q[$];
  logic last_vld = 1'b0;

  dma_prio_arbiter #(.NCH(NCH)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_req    (req),
    .ch_prio   (pr),
    .ch_m2m    (m2m),
    .xfer_done (done),
    .gnt       (gnt),
    .gnt_vld   (gnt_vld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: on each newly issued grant, pop the expected channel and compare.
  always @(posedge clk) begin
    #2;
    if (rst_n && gnt_vld && !last_vld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected grant", 32'(gnt), 0);
      end else begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(gnt == NCH'(1 << e), t, 32'(gnt), 32'(1 << e));
      end
    end
    last_vld = rst_n && gnt_vld;
  end

  // Driver: presents a request set in an idle cycle, expects channel exp
  // (or no grant when exp < 0), holds with hold_req, then completes the transfer.
  task automatic arb(input logic [NCH-1:0] r, input logic [NCH-1:0] mm,
                     input int exp, input logic [NCH-1:0] hold_req, input string tag);
    logic [NCH-1:0] g0;
    if (exp >= 0) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    req = r;
    m2m = mm;
    @(negedge clk);
    if (exp < 0) begin
      check(!gnt_vld && gnt == '0, "R6 idle without requests", 32'(gnt_vld), 0);
      return;
    end
    check(gnt_vld, "R5 grant one edge after request", 32'(gnt_vld), 1);
    g0 = gnt;
    req = hold_req;
    @(negedge clk);
    @(negedge clk);
    check(gnt_vld && gnt == g0, "R7 grant held during busy", 32'(gnt), 32'(g0));
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    req = '0;
    check(!gnt_vld && gnt == '0, "R5 released after done", 32'(gnt), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    req = '0; pr = '0; m2m = '0; done = 1'b0;
    repeat (3) @(negedge clk);
    check(!gnt_vld && gnt == '0, "R9 reset state", 32'(gnt), 0);
    rst_n = 1'b1;
    @(negedge clk);

    arb('0, '0, -1, '0, "R6");

    pr[1] = 2'b00; pr[3] = 2'b01; pr[5] = 2'b11;
    arb(7'b0101010, '0, 5, '0, "R1 very high beats medium and low");

    pr[2] = 2'b10; pr[4] = 2'b10; pr[6] = 2'b10;
    arb(7'b1010100, '0, 2, '0, "R2 lowest index among high");

    pr[0] = 2'b00; pr[6] = 2'b10;
    arb(7'b1000001, '0, 6, '0, "R1 high beats low");

    // Memory-to-memory channel 1 at very high, channel 4 at low.
    pr[1] = 2'b11; pr[4] = 2'b00; pr[3] = 2'b01; pr[5] = 2'b10;
    arb(7'b0000010, 7'b0000010, 1, '0, "R4 lone m2m first grant");
    arb(7'b0010010, 7'b0000010, 4, '0, "R3 m2m yields to low channel");
    arb(7'b0010010, 7'b0000010, 1, '0, "R10 after normal channel, priority applies");
    arb(7'b0000010, 7'b0000010, 1, '0, "R4 lone m2m regranted");
    arb(7'b0000010, 7'b0000010, 1, '0, "R4 lone m2m regranted again");
    arb(7'b0101010, 7'b0000010, 5, '0, "R3 yield goes to best other requester");

    pr[2] = 2'b11; pr[0] = 2'b00;
    arb(7'b0000101, '0, 2, '0, "R10 normal channel first");
    arb(7'b0000101, '0, 2, '0, "R10 normal channel wins again");

    // Request from channel 6 raised and dropped while busy.
    arb(7'b0000001, '0, 0, 7'b1000000, "R7 busy, ch6 pulses");
    pr[4] = 2'b00;
    arb(7'b0010000, '0, 4, '0, "R7 withdrawn request not granted");

    // Spurious done while idle.
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    @(negedge clk);
    check(!gnt_vld && gnt == '0, "R8 idle done ignored", 32'(gnt_vld), 0);
    pr[3] = 2'b01;
    arb(7'b0001000, '0, 3, '0, "R8 arbitration normal after idle done");

    // Asynchronous reset while a grant is outstanding, yield history cleared.
    exp_q.push_back(1); tag_q.push_back("R9 m2m grant before reset");
    req = 7'b0000010; m2m = 7'b0000010;
    @(negedge clk);
    req = '0;
    #1 rst_n = 1'b0;
    #1 check(!gnt_vld && gnt == '0, "R9 async clear", 32'(gnt), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    arb(7'b0010010, 7'b0000010, 1, '0, "R9 yield history cleared");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule